// File: doc/BRIEF.md
# Synthesizer Reference/Feedback Divider with Phase-Lock Detector

This block is the digital heart of a single-loop frequency synthesizer. The system clock is the stable reference. It is divided by one of four fixed ratios to give the comparison rate. A separate input carries the buffered oscillator signal as a clock of its own. That signal passes through a fixed divide-by-10 prescaler and then a programmable divide-by-N counter. The divided feedback is brought into the reference domain and compared with the divided reference. Only the leading edge of each divided signal is used.

The comparator produces two correction pulses. One raises the oscillator frequency when the feedback lags. The other lowers it when the feedback leads. An external loop filter integrates them. A lock monitor counts the active correction cycles in each comparison period. A period with too much activity raises an out-of-lock flag. The flag stays raised until a run of good periods has been seen.

Top module: `synth_lock_core`

## Requirements
- R1: While reset is held and just after it is released, `unlocked` is 1 and both `pump_up` and `pump_dn` are 0.
- R2: The reference is divided by 4, 16, 64 or 100 for `ref_sel` values 0, 1, 2 and 3. A loop runs in lock only when the feedback rate matches the selected ratio.
- R3: The feedback is divided by 10 times N in total. The loop locks when the oscillator period equals the comparison period divided by 10·N.
- R4: A divide value below 7 acts as 7, and a value above 36 acts as 36.
- R5: A reference edge with no pending feedback edge starts `pump_up` on the next cycle, which signals that the feedback lags. A feedback edge with no pending reference edge starts `pump_dn` on the next cycle, which signals that the feedback leads. With the feedback running slow, `pump_up` dominates; with it running fast, `pump_dn` dominates.
- R6: `pump_up` and `pump_dn` are never 1 in the same cycle. When both edges are present, neither pulse is left standing.
- R7: When a comparison period holds more active pump cycles than `lock_thresh`, `unlocked` goes to 1 in the cycle after that period ends.
- R8: `unlocked` falls only after 16 consecutive good periods. After reset with every period good, it falls one cycle after the 16th reference edge, that is, 16·ratio+1 cycles after reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; all comparison logic runs on it |
| rst | input | 1 | Synchronous reset, active high |
| ref_sel | input | 2 | Reference ratio select (0:4, 1:16, 2:64, 3:100) |
| fb_clk | input | 1 | Buffered oscillator feedback, used as a clock |
| div_n | input | 8 | Feedback divide value, clamped to 7..36 |
| lock_thresh | input | 8 | Largest count of active pump cycles per period still judged good |
| pump_up | output | 1 | Correction pulse that raises the oscillator frequency |
| pump_dn | output | 1 | Correction pulse that lowers the oscillator frequency |
| unlocked | output | 1 | Stretched out-of-lock flag |

## Verification
Two events can land in the same reference cycle. One is a divided reference edge and the other is a divided feedback edge that has passed through the synchronizer. In lock this happens all the time. The bench closes the loop with a behavioural oscillator that it nudges from the pump outputs, so the two edges are driven toward coincidence and keep landing there. In that state, correct coincidence handling shows as pumps that never overlap and almost never fire, so the lock flag clears and then stays clear across many periods. A stuck pump would instead hold the activity count above the threshold.

// File: rtl/sl_pkg.sv
`timescale 1ns/1ps
package sl_pkg;

   typedef struct packed {
      logic up;
      logic dn;
   } pump_t;

   function automatic int unsigned pick_ratio(input logic [1:0] sel,
                                              input int unsigned r0,
                                              input int unsigned r1,
                                              input int unsigned r2,
                                              input int unsigned r3);
      case (sel)
         2'd0:    return r0;
         2'd1:    return r1;
         2'd2:    return r2;
         default: return r3;
      endcase
   endfunction

endpackage

// File: rtl/sl_bit_sync.sv
`timescale 1ns/1ps
module sl_bit_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("sl_bit_sync: STAGES must be at least 1");
      end
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk) chain[0] <= d;
      end else begin : g_chain
         always_ff @(posedge clk) chain <= {chain[STAGES-2:0], d};
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/sl_ref_div.sv
`timescale 1ns/1ps
module sl_ref_div import sl_pkg::*; #(
   parameter int unsigned RATIO0 = 4,
   parameter int unsigned RATIO1 = 16,
   parameter int unsigned RATIO2 = 64,
   parameter int unsigned RATIO3 = 100
) (
   input  logic       clk,
   input  logic       rst,
   input  logic [1:0] sel,
   output logic       tick
);
   localparam int unsigned MAX01 = (RATIO0 > RATIO1) ? RATIO0 : RATIO1;
   localparam int unsigned MAX23 = (RATIO2 > RATIO3) ? RATIO2 : RATIO3;
   localparam int unsigned RMAX  = (MAX01 > MAX23) ? MAX01 : MAX23;
   localparam int          CW    = $clog2(RMAX);

   generate
      if (RATIO0 < 2 || RATIO1 < 2 || RATIO2 < 2 || RATIO3 < 2) begin : g_bad_ratio
         $error("sl_ref_div: every ratio must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt;
   logic [CW-1:0] last;

   always_comb last = CW'(pick_ratio(sel, RATIO0, RATIO1, RATIO2, RATIO3) - 1);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt  <= '0;
         tick <= 1'b0;
      end else if (cnt >= last) begin
         cnt  <= '0;
         tick <= 1'b1;
      end else begin
         cnt  <= cnt + 1'b1;
         tick <= 1'b0;
      end
   end
endmodule

// File: rtl/sl_fb_div.sv
`timescale 1ns/1ps
module sl_fb_div #(
   parameter int PRESCALE = 10,
   parameter int N_W      = 8,
   parameter int N_MIN    = 7,
   parameter int N_MAX    = 36
) (
   input  logic           fb_clk,
   input  logic           fb_rst,
   input  logic [N_W-1:0] div_n,
   output logic           mark
);
   localparam int PW = $clog2(PRESCALE);

   generate
      if (PRESCALE < 2) begin : g_bad_pre
         $error("sl_fb_div: PRESCALE must be at least 2");
      end
      if (N_MIN < 2 || N_MAX < N_MIN || N_MAX >= (1 << N_W)) begin : g_bad_n
         $error("sl_fb_div: divide limits do not fit N_W");
      end
   endgenerate

   logic [PW-1:0]  pre;
   logic [N_W-1:0] ncnt;
   logic [N_W-1:0] n_act;
   logic [N_W-1:0] n_lim;
   logic           pre_wrap;
   logic           n_wrap;

   always_comb begin
      if (div_n < N_W'(N_MIN))      n_lim = N_W'(N_MIN);
      else if (div_n > N_W'(N_MAX)) n_lim = N_W'(N_MAX);
      else                          n_lim = div_n;
   end

   assign pre_wrap = (pre == PW'(PRESCALE - 1));
   assign n_wrap   = pre_wrap && (ncnt == n_act - 1'b1);

   always_ff @(posedge fb_clk) begin
      if (fb_rst) begin
         pre   <= '0;
         ncnt  <= '0;
         n_act <= n_lim;
         mark  <= 1'b0;
      end else begin
         pre <= pre_wrap ? '0 : pre + 1'b1;
         if (n_wrap) begin
            ncnt  <= '0;
            n_act <= n_lim;
         end else if (pre_wrap) begin
            ncnt <= ncnt + 1'b1;
         end
         mark <= (ncnt < (n_act >> 1));
      end
   end
endmodule

// File: rtl/sl_phase_lock.sv
`timescale 1ns/1ps
module sl_phase_lock import sl_pkg::*; #(
   parameter int ACT_W    = 8,
   parameter int GOOD_RUN = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ref_tick,
   input  logic             fb_tick,
   input  logic [ACT_W-1:0] thresh,
   output logic             pump_up,
   output logic             pump_dn,
   output logic             unlocked
);
   localparam int GW = $clog2(GOOD_RUN + 1);

   generate
      if (GOOD_RUN < 1) begin : g_bad_run
         $error("sl_phase_lock: GOOD_RUN must be at least 1");
      end
   endgenerate

   pump_t            nxt;
   logic [ACT_W-1:0] act;
   logic [GW-1:0]    good;

   always_comb begin
      nxt.up = pump_up | ref_tick;
      nxt.dn = pump_dn | fb_tick;
      if (nxt.up && nxt.dn) nxt = '0;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pump_up  <= 1'b0;
         pump_dn  <= 1'b0;
         act      <= '0;
         good     <= '0;
         unlocked <= 1'b1;
      end else begin
         pump_up <= nxt.up;
         pump_dn <= nxt.dn;
         if (ref_tick) begin
            act <= '0;
            if (act > thresh) begin
               unlocked <= 1'b1;
               good     <= '0;
            end else if (good == GW'(GOOD_RUN - 1)) begin
               unlocked <= 1'b0;
            end else begin
               good <= good + 1'b1;
            end
         end else if ((pump_up || pump_dn) && act != '1) begin
            act <= act + 1'b1;
         end
      end
   end
endmodule

// File: rtl/synth_lock_core.sv
`timescale 1ns/1ps
module synth_lock_core #(
   parameter int unsigned REF_RATIO0 = 4,
   parameter int unsigned REF_RATIO1 = 16,
   parameter int unsigned REF_RATIO2 = 64,
   parameter int unsigned REF_RATIO3 = 100,
   parameter int          PRESCALE    = 10,
   parameter int          DIV_W       = 8,
   parameter int          DIV_MIN     = 7,
   parameter int          DIV_MAX     = 36,
   parameter int          ACT_W       = 8,
   parameter int          GOOD_RUN    = 16,
   parameter int          SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [1:0]       ref_sel,
   input  logic             fb_clk,
   input  logic [DIV_W-1:0] div_n,
   input  logic [ACT_W-1:0] lock_thresh,
   output logic             pump_up,
   output logic             pump_dn,
   output logic             unlocked
);
   logic ref_tick;
   logic fb_rst;
   logic fb_mark;
   logic mark_s;
   logic mark_d;
   logic fb_tick;

   sl_ref_div #(
      .RATIO0(REF_RATIO0), .RATIO1(REF_RATIO1),
      .RATIO2(REF_RATIO2), .RATIO3(REF_RATIO3)
   ) u_ref (
      .clk(clk), .rst(rst), .sel(ref_sel), .tick(ref_tick)
   );

   sl_bit_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
      .clk(fb_clk), .d(rst), .q(fb_rst)
   );

   sl_fb_div #(
      .PRESCALE(PRESCALE), .N_W(DIV_W), .N_MIN(DIV_MIN), .N_MAX(DIV_MAX)
   ) u_fb (
      .fb_clk(fb_clk), .fb_rst(fb_rst), .div_n(div_n), .mark(fb_mark)
   );

   sl_bit_sync #(.STAGES(SYNC_STAGES)) u_mark_sync (
      .clk(clk), .d(fb_mark), .q(mark_s)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         mark_d  <= 1'b0;
         fb_tick <= 1'b0;
      end else begin
         mark_d  <= mark_s;
         fb_tick <= mark_s & ~mark_d;
      end
   end

   sl_phase_lock #(.ACT_W(ACT_W), .GOOD_RUN(GOOD_RUN)) u_pl (
      .clk(clk), .rst(rst), .ref_tick(ref_tick), .fb_tick(fb_tick),
      .thresh(lock_thresh), .pump_up(pump_up), .pump_dn(pump_dn),
      .unlocked(unlocked)
   );
endmodule

// File: rtl/synth_lock_core_chk.sv
`timescale 1ns/1ps
module synth_lock_core_chk import sl_pkg::*; #(
   parameter int unsigned RATIO0   = 4,
   parameter int unsigned RATIO1   = 16,
   parameter int unsigned RATIO2   = 64,
   parameter int unsigned RATIO3   = 100,
   parameter int          GOOD_RUN = 16
) (
   input logic       clk,
   input logic       rst,
   input logic [1:0] ref_sel,
   input logic       ref_tick,
   input logic       fb_tick,
   input logic       pump_up,
   input logic       pump_dn,
   input logic       unlocked
);
   localparam int unsigned MAX01 = (RATIO0 > RATIO1) ? RATIO0 : RATIO1;
   localparam int unsigned MAX23 = (RATIO2 > RATIO3) ? RATIO2 : RATIO3;
   localparam int unsigned RMAX  = (MAX01 > MAX23) ? MAX01 : MAX23;
   localparam int          GW    = $clog2(RMAX) + 2;
   localparam int          RW    = $clog2(GOOD_RUN + 1) + 1;

   logic [GW-1:0] gap;
   logic          seen;
   logic          sel_ok;
   logic [1:0]    sel_prev;
   logic [RW-1:0] run_ticks;

   always_ff @(posedge clk) begin
      if (rst) begin
         gap      <= '0;
         seen     <= 1'b0;
         sel_ok   <= 1'b1;
         sel_prev <= ref_sel;
      end else begin
         sel_prev <= ref_sel;
         if (ref_tick) begin
            gap    <= GW'(1);
            seen   <= 1'b1;
            sel_ok <= 1'b1;
         end else begin
            if (gap != '1) gap <= gap + 1'b1;
            if (ref_sel != sel_prev) sel_ok <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst || !unlocked) run_ticks <= '0;
      else if (ref_tick && run_ticks != '1) run_ticks <= run_ticks + 1'b1;
   end

   // R2: spacing of reference edges follows the selected ratio
   assert_ref_ratio_R2: assert property (@(posedge clk) disable iff (rst)
      (ref_tick && seen && sel_ok) |->
         (gap == GW'(pick_ratio(ref_sel, RATIO0, RATIO1, RATIO2, RATIO3))));

   // R5: up pulse only starts after a reference edge
   assert_up_after_ref_R5: assert property (@(posedge clk) disable iff (rst)
      $rose(pump_up) |-> $past(ref_tick));

   // R5: down pulse only starts after a feedback edge
   assert_dn_after_fb_R5: assert property (@(posedge clk) disable iff (rst)
      $rose(pump_dn) |-> $past(fb_tick));

   // R6: the two correction outputs never overlap
   assert_pumps_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
      !(pump_up && pump_dn));

   // R7: out-of-lock is only raised at a period boundary
   assert_unlock_at_edge_R7: assert property (@(posedge clk) disable iff (rst)
      $rose(unlocked) |-> $past(ref_tick));

   // R8: clearing needs a full run of reference periods while flagged
   assert_clear_after_run_R8: assert property (@(posedge clk) disable iff (rst)
      $fell(unlocked) |-> (run_ticks >= RW'(GOOD_RUN)));
endmodule

bind synth_lock_core synth_lock_core_chk #(
   .RATIO0(REF_RATIO0), .RATIO1(REF_RATIO1),
   .RATIO2(REF_RATIO2), .RATIO3(REF_RATIO3),
   .GOOD_RUN(GOOD_RUN)
) u_chk (
   .clk(clk), .rst(rst), .ref_sel(ref_sel), .ref_tick(ref_tick),
   .fb_tick(fb_tick), .pump_up(pump_up), .pump_dn(pump_dn),
   .unlocked(unlocked)
);

// File: tb/sim_synth_lock_core.sv
`timescale 1ns/1ps
module sim_synth_lock_core;
   localparam real CLK_NS   = 10.0;
   localparam int  WATCHDOG = 195000;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [1:0] ref_sel = 2'd3;
   logic       fb_clk;
   logic [7:0] div_n = 8'd20;
   logic [7:0] lock_thresh = 8'd2;
   logic       pump_up;
   logic       pump_dn;
   logic       unlocked;

   int      n_checks = 0;
   int      n_fail   = 0;
   bit      fb_run   = 1'b0;
   bit      loop_on  = 1'b0;
   realtime fb_half  = 2.5;
   int      kick_req = 0;
   realtime kick_ns  = 0.0;
   int      loop_dir = 0;

   synth_lock_core u0 (
      .clk(clk), .rst(rst), .ref_sel(ref_sel), .fb_clk(fb_clk),
      .div_n(div_n), .lock_thresh(lock_thresh),
      .pump_up(pump_up), .pump_dn(pump_dn), .unlocked(unlocked)
   );

   initial forever #(CLK_NS / 2.0) clk = ~clk;

   // behavioural oscillator, optionally steered by the correction pulses
   always @(negedge clk) loop_dir <= pump_dn ? 1 : (pump_up ? -1 : 0);

   initial begin
      realtime d;
      int kick_done;
      kick_done = 0;
      fb_clk = 1'b0;
      forever begin
         if (!fb_run) begin
            fb_clk = 1'b0;
            #5;
         end else begin
            d = fb_half;
            if (loop_on) d = d + loop_dir * 0.2 * fb_half;
            if (kick_done != kick_req) begin
               d = d + kick_ns;
               kick_done = kick_req;
            end
            #(d) fb_clk = ~fb_clk;
         end
      end
   end

   function automatic int ratio_of(input int s);
      case (s)
         0: return 4;
         1: return 16;
         2: return 64;
         default: return 100;
      endcase
   endfunction

   function automatic int clamp_div(input int n);
      if (n < 7) return 7;
      if (n > 36) return 36;
      return n;
   endfunction

   function automatic realtime half_for(input int s, input int n);
      return ratio_of(s) * CLK_NS / (2.0 * 10.0 * n);
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input int got, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
      end
   endtask

   task automatic do_reset();
      rst = 1'b1;
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic wait_flag(input logic lvl, input int maxc,
                            output int cyc, output bit hit);
      cyc = 0;
      hit = 1'b0;
      while (cyc < maxc && !hit) begin
         @(negedge clk);
         cyc++;
         if (unlocked == lvl) hit = 1'b1;
      end
   endtask

   task automatic count_pumps(input int cycles, output int ups, output int dns);
      ups = 0;
      dns = 0;
      repeat (cycles) begin
         @(negedge clk);
         if (pump_up) ups++;
         if (pump_dn) dns++;
      end
   endtask

   task automatic run_lock(input int s, input int n, input string req);
      int cyc;
      bit hit;
      bit stays;
      int r;
      r = ratio_of(s);
      ref_sel = 2'(s);
      div_n = 8'(n);
      lock_thresh = 8'd2;
      fb_half = half_for(s, clamp_div(n));
      fb_run = 1'b1;
      loop_on = 1'b1;
      do_reset();
      wait_flag(1'b0, 90 * r, cyc, hit);
      check(hit, req, $sformatf("lock sel=%0d n=%0d", s, n), int'(unlocked), 0);
      stays = 1'b1;
      repeat (10 * r) begin
         @(negedge clk);
         if (unlocked) stays = 1'b0;
      end
      check(stays, req, $sformatf("lock held sel=%0d n=%0d", s, n), int'(stays), 1);
   endtask

   task automatic run_all();
      int ups;
      int dns;
      int cyc;
      bit hit;
      int r;
      int s;
      int n;
      int seed_dummy;
      seed_dummy = $urandom(32'd20240611);

      // R1: state during and after reset
      rst = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(unlocked == 1'b1, "R1", "unlocked in reset", int'(unlocked), 1);
      check(!pump_up && !pump_dn, "R1", "pumps in reset", int'({pump_up, pump_dn}), 0);
      rst = 1'b0;
      @(negedge clk);
      check(unlocked == 1'b1 && !pump_up && !pump_dn, "R1", "after release",
            int'({unlocked, pump_up, pump_dn}), 4);

      // R7 and R5: no feedback, zero threshold: up held, flag stays
      ref_sel = 2'd0;
      lock_thresh = 8'd0;
      fb_run = 1'b0;
      do_reset();
      repeat (160) @(posedge clk);
      count_pumps(40, ups, dns);
      check(unlocked == 1'b1, "R7", "active periods keep flag", int'(unlocked), 1);
      check(ups > 30 && dns == 0, "R5", "missing feedback gives up only", ups, 40);

      // R8: randomized ratio, every period good, exact clear time
      for (int i = 0; i < 6; i++) begin
         s = int'($urandom % 4);
         r = ratio_of(s);
         ref_sel = 2'(s);
         lock_thresh = 8'd255;
         do_reset();
         repeat (16 * r - 4) @(posedge clk);
         @(negedge clk);
         check(unlocked == 1'b1, "R8", $sformatf("still set sel=%0d", s), int'(unlocked), 1);
         repeat (8) @(posedge clk);
         @(negedge clk);
         check(unlocked == 1'b0, "R8", $sformatf("cleared sel=%0d", s), int'(unlocked), 0);
      end

      // R2/R3: closed-loop lock at each ratio with a matching oscillator
      run_lock(0, 8, "R2");
      run_lock(1, 8, "R2");
      run_lock(2, 16, "R3");
      run_lock(3, 20, "R3");

      // R4: clamped divide values, directed and random
      run_lock(3, 3, "R4");
      run_lock(3, 200, "R4");
      for (int i = 0; i < 2; i++) begin
         n = int'($urandom % 256);
         run_lock(3, n, "R4");
      end

      // R8/R7: phase disturbance in lock, then recovery
      loop_on = 1'b0;
      kick_ns = 300.0;
      kick_req++;
      wait_flag(1'b1, 400, cyc, hit);
      check(hit, "R7", "disturbance raises flag", int'(unlocked), 1);
      loop_on = 1'b1;
      wait_flag(1'b0, 9000, cyc, hit);
      check(hit, "R8", "recovers after disturbance", int'(unlocked), 0);
      check(cyc >= 16 * 100 - 2, "R8", "held for a full run", cyc, 1598);

      // R2/R5: mismatched rates, loop open
      loop_on = 1'b0;
      lock_thresh = 8'd2;
      ref_sel = 2'd2;
      div_n = 8'd20;
      fb_half = half_for(3, 20);
      do_reset();
      repeat (1400) @(posedge clk);
      count_pumps(5000, ups, dns);
      check(ups > dns, "R5", "slow feedback favours up", ups, dns + 1);
      check(unlocked == 1'b1, "R2", "wrong ratio stays unlocked", int'(unlocked), 1);

      ref_sel = 2'd3;
      fb_half = 2.0;
      do_reset();
      repeat (1400) @(posedge clk);
      count_pumps(5000, ups, dns);
      check(dns > ups, "R5", "fast feedback favours down", dns, ups + 1);
      check(unlocked == 1'b1, "R7", "fast feedback stays unlocked", int'(unlocked), 1);
      check(!(pump_up && pump_dn), "R6", "no overlap at end", int'({pump_up, pump_dn}), 0);
   endtask

   initial begin
      bit timed_out;
      timed_out = 1'b0;
      fork
         run_all();
         begin
            repeat (WATCHDOG) @(posedge clk);
            timed_out = 1'b1;
         end
      join_any
      if (timed_out) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
      end
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule